// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block is the bus master sequencer for a 32-bit external bus on which address and data share the same wires. An internal client hands it one request at a time: an address, a direction, a beat count, a lane mask for the first beat and a write word. The sequencer then runs an Address cycle, any number of device-paced Wait cycles, one Data cycle per beat, a programmable number of Recovery cycles and then Idle. The attributes of each access come from one of eight address regions, each 512 MB in size. A region sets the port width (8, 16 or 32 bits), whether bursts are limited to four beats or may run to sixteen, how many recovery cycles follow the access, and whether a four-beat burst starts at the line base or at the target word.

The pins are modelled as plain outputs plus output-enable flags instead of tri-state pads. On narrow ports some byte-enable pins carry the low address bits. The two partial word-address outputs step on every completed beat. An external master can take the bus with a request/acknowledge handshake. The sequencer grants it only between accesses, and while it holds the bus, the bus request output shows whether internal work is waiting.

Top module: `mbus_ctrl`

## Requirements
- R1: Request address bits 31:29 select region i, whose 6-bit field is region_cfg[6i+5:6i]: bits 1:0 width code, bits 3:2 recovery count, bit 4 long-burst enable, bit 5 target-word-first. Width code 11 behaves as 32-bit and is reported as 10.
- R2: A request accepted on an edge where req_ready is high gives exactly one Address cycle in the next cycle, with ale high. wr is high in that cycle only for writes and is low in every other cycle.
- R3: In the Address cycle bus_oe is high and bus_out carries the beat-0 address A as follows: bus_out[7:0]=A[31:24], bus_out[15:8]=A[23:16], bus_out[23:16]=A[15:8], bus_out[31:28]=A[7:4].
- R4: If long-burst is enabled, the access has req_len+1 beats (1 to 16) and bus_out[27:24]=req_len in the Address cycle. Otherwise it has (req_len mod 4)+1 beats, bus_out[25:24] holds that count minus one, and bus_out[27:26]=00.
- R5: After the Address cycle, each cycle with rdy high completes one beat and each cycle with rdy low is a Wait cycle. blast is high from the Address cycle of the final beat (for single accesses) through that beat's Wait cycles to its completion, and low otherwise.
- R6: During Address and Data/Wait cycles bus_width shows the region width: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit.
- R7: be_n[k] enables lane k = bus bits 31-8k down to 24-8k, and is active low. 32-bit: be_n = ~req_lanes on beat 0 and 0000 on later beats. 16-bit: be_n[0]=be_n[2]=0, be_n[1]=address bit 1, be_n[3]=1. 8-bit: be_n[0]=address bit 0, be_n[1]=address bit 1, be_n[3:2]=11. be_n is 1111 outside an access.
- R8: The beat address starts at the request address aligned down to the port width in bytes. If a burst has long-burst disabled and target-word-first cleared, it starts at the 16-byte line base instead. Each beat adds the width in bytes. Bursts with long-burst disabled wrap inside the 16-byte line. part_addr shows address bits 3:2 of the current beat.
- R9: Each completed read beat gives rd_valid one cycle later, with rd_data equal to the bus_in value sampled on that beat. On write beats bus_oe is high and bus_out = req_wdata.
- R10: If bus_err_n is low on a cycle where rdy is high, the access ends after that beat and done_err is set with done. bus_err_n has no effect on cycles where rdy is low.
- R11: done pulses one cycle after the final beat. req_ready then stays low for exactly the region's recovery count (0 to 3) of cycles and then goes high.
- R12: When hold_req is high and no access is running, hold_ack rises on the next cycle, and ctl_oe and bus_oe are low while hold_ack is high. A hold request raised during an access is granted only after the access ends. hold_ack falls one cycle after hold_req is sampled low. req_ready is low while hold_req is high.
- R13: While hold_ack is high, bus_req follows req_valid. During Address, Data/Wait and Recovery cycles bus_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| region_cfg | input | 48 | Eight 6-bit region attribute fields |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_len | input | 4 | Requested beats minus one |
| req_lanes | input | 4 | First-beat lane enables, active high (32-bit port) |
| req_wdata | input | 32 | Write word driven on every write beat |
| rd_valid | output | 1 | Read beat data valid |
| rd_data | output | 32 | Read beat data |
| done | output | 1 | Access finished |
| done_err | output | 1 | Finished access saw a bus error |
| bus_out | output | 32 | Multiplexed bus, driven value |
| bus_in | input | 32 | Multiplexed bus, sampled value |
| bus_oe | output | 1 | Drive enable for bus_out |
| ctl_oe | output | 1 | Drive enable for control outputs |
| ale | output | 1 | Address latch enable |
| wr | output | 1 | Write/read indication |
| be_n | output | 4 | Byte enables / low address bits |
| part_addr | output | 2 | Word address bits 3:2 |
| blast | output | 1 | Final beat marker |
| bus_width | output | 2 | Port width code |
| rdy | input | 1 | Device ready |
| bus_err_n | input | 1 | Bus error, active low |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus handed to external master |
| bus_req | output | 1 | Bus wanted / in use |

## Verification
ale, wr, the Address-cycle bus word and be_n change one edge after req_ready accepts a request. Beat outputs (blast, be_n, part_addr, write data) reflect the current beat while rdy is high, and rd_valid and done come one edge after the completing beat. The bench drives inputs just after a rising edge and samples on the falling edge of the cycle where each result is due. A monitor pops expected Address, beat, done and read items in order whenever ale or rdy or done or rd_valid is seen. The driver counts the low cycles of req_ready after the last beat to check the recovery count, and it follows the hold handshake one cycle at a time.

// File: rtl/mbus_pkg.sv
// Shared types for the multiplexed bus sequencer.
// Assumes a region attribute field of exactly ATTR_W bits.
package mbus_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ATTR_W = 6;

    localparam logic [1:0] W8  = 2'b00;
    localparam logic [1:0] W16 = 2'b01;
    localparam logic [1:0] W32 = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_DATA,
        S_RECOV,
        S_HOLD
    } bus_state_t;

    typedef struct packed {
        logic       twf;
        logic       multi;
        logic [1:0] recov;
        logic [1:0] width;
    } region_attr_t;
endpackage

// File: rtl/mbus_region_sel.sv
// Region attribute selector: unpacks the flat configuration vector into
// NREG attribute fields and picks the one addressed by sel.
// Assumes NREG is a power of two so that sel covers every entry.
module mbus_region_sel
    import mbus_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int SEL_W = $clog2(NREG)
) (
    input  logic [NREG*ATTR_W-1:0] cfg,
    input  logic [SEL_W-1:0]       sel,
    output region_attr_t           attr
);
    timeunit 1ns;
    timeprecision 1ps;

    region_attr_t regs_arr [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_unpack
            assign regs_arr[g] = region_attr_t'(cfg[g*ATTR_W +: ATTR_W]);
        end
    endgenerate

    // Pick the addressed region and fold the reserved width onto 32-bit.
    always_comb begin
        attr = regs_arr[sel];
        if (attr.width == 2'b11) begin
            attr.width = W32;
        end
    end
endmodule

// File: rtl/mbus_beat_addr.sv
// Beat address generator: computes the first beat address at request
// acceptance and steps it by the port width on each completed beat,
// wrapping inside a line when asked. Assumes LINE_BYTES is a power of two
// of at least 4.
module mbus_beat_addr
    import mbus_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] req_addr,
    input  region_attr_t  attr_in,
    input  logic          burst_in,
    input  logic [1:0]    width_q,
    input  logic          wrap_q,
    output logic [AW-1:0] cur_addr
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LW = $clog2(LINE_BYTES);

    function automatic logic [2:0] step_of(input logic [1:0] w);
        case (w)
            W8:      step_of = 3'd1;
            W16:     step_of = 3'd2;
            default: step_of = 3'd4;
        endcase
    endfunction

    logic [AW-1:0] start_addr;
    logic [AW-1:0] sum_addr;
    logic [AW-1:0] next_addr;

    // First beat address: width alignment, optional line-base start.
    always_comb begin
        start_addr = req_addr & ~(AW'(step_of(attr_in.width)) - AW'(1));
        if (burst_in && !attr_in.multi && !attr_in.twf) begin
            start_addr[LW-1:0] = '0;
        end
    end

    // Following beat address: plain increment or wrap inside the line.
    always_comb begin
        sum_addr = cur_addr + AW'(step_of(width_q));
        if (wrap_q) begin
            next_addr = {cur_addr[AW-1:LW], sum_addr[LW-1:0]};
        end else begin
            next_addr = sum_addr;
        end
    end

    // Address register: load on accept, step on each completed beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (load) begin
            cur_addr <= start_addr;
        end else if (advance) begin
            cur_addr <= next_addr;
        end
    end
endmodule

// File: rtl/mbus_lane_map.sv
// Byte-enable encoder: maps lane mask and low address bits onto the four
// active-low enable pins according to the port width.
// Assumes width never carries the reserved code (folded upstream).
module mbus_lane_map
    import mbus_pkg::*;
(
    input  logic       active,
    input  logic [1:0] width,
    input  logic [1:0] addr_lo,
    input  logic [3:0] lane_en,
    output logic [3:0] be_n
);
    timeunit 1ns;
    timeprecision 1ps;

    // Width-dependent pin meaning; all high outside an access.
    always_comb begin
        if (!active) begin
            be_n = 4'hF;
        end else begin
            case (width)
                W8:      be_n = {2'b11, addr_lo[1], addr_lo[0]};
                W16:     be_n = {1'b1, 1'b0, addr_lo[1], 1'b0};
                default: be_n = ~lane_en;
            endcase
        end
    end
endmodule

// File: rtl/mbus_ctrl.sv
// Multiplexed bus sequencer top: accepts one request at a time, runs the
// Address / Wait / Data / Recovery / Idle cycle sequence with per-region
// attributes, and grants the bus to an external master between accesses.
// Assumes AW = 32 (fixed pin mapping) and a single outstanding request.
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter int AW         = 32,
    parameter int NREG       = 8,
    parameter int LINE_BYTES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREG*ATTR_W-1:0] region_cfg,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [3:0]           req_len,
    input  logic [3:0]           req_lanes,
    input  logic [31:0]          req_wdata,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic                 done,
    output logic                 done_err,
    output logic [31:0]          bus_out,
    input  logic [31:0]          bus_in,
    output logic                 bus_oe,
    output logic                 ctl_oe,
    output logic                 ale,
    output logic                 wr,
    output logic [3:0]           be_n,
    output logic [1:0]           part_addr,
    output logic                 blast,
    output logic [1:0]           bus_width,
    input  logic                 rdy,
    input  logic                 bus_err_n,
    input  logic                 hold_req,
    output logic                 hold_ack,
    output logic                 bus_req
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SEL_W = $clog2(NREG);

    bus_state_t   state;
    region_attr_t attr_in;
    region_attr_t attr_q;
    logic         write_q;
    logic         first_q;
    logic [3:0]   lanes_q;
    logic [3:0]   len_q;
    logic [3:0]   beats_left;
    logic [1:0]   rcnt;
    logic [31:0]  wdata_q;
    logic [3:0]   len_eff;
    logic         accept;
    logic         beat_done;
    logic         finish;
    logic         advance;
    logic         active;
    logic [AW-1:0] cur_addr;

    mbus_region_sel #(.NREG(NREG), .SEL_W(SEL_W)) u_region (
        .cfg  (region_cfg),
        .sel  (req_addr[AW-1 -: SEL_W]),
        .attr (attr_in)
    );

    mbus_beat_addr #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .advance  (advance),
        .req_addr (req_addr),
        .attr_in  (attr_in),
        .burst_in (len_eff != 4'd0),
        .width_q  (attr_q.width),
        .wrap_q   (!attr_q.multi),
        .cur_addr (cur_addr)
    );

    mbus_lane_map u_lanes (
        .active  (active),
        .width   (attr_q.width),
        .addr_lo (cur_addr[1:0]),
        .lane_en (first_q ? lanes_q : 4'hF),
        .be_n    (be_n)
    );

    // Handshake and beat events derived from the current state.
    always_comb begin
        len_eff   = attr_in.multi ? req_len : {2'b00, req_len[1:0]};
        req_ready = (state == S_IDLE) && !hold_req;
        accept    = req_ready && req_valid;
        beat_done = (state == S_DATA) && rdy;
        finish    = beat_done && (!bus_err_n || beats_left == 4'd0);
        advance   = beat_done && !finish;
        active    = (state == S_ADDR) || (state == S_DATA);
    end

    // Cycle sequencer: Idle -> Address -> Wait/Data -> Recovery, plus hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            rcnt  <= 2'd0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (hold_req) begin
                        state <= S_HOLD;
                    end else if (req_valid) begin
                        state <= S_ADDR;
                    end
                end
                S_ADDR: state <= S_DATA;
                S_DATA: begin
                    if (finish) begin
                        if (attr_q.recov == 2'd0) begin
                            state <= S_IDLE;
                        end else begin
                            state <= S_RECOV;
                            rcnt  <= attr_q.recov - 2'd1;
                        end
                    end
                end
                S_RECOV: begin
                    if (rcnt == 2'd0) begin
                        state <= S_IDLE;
                    end else begin
                        rcnt <= rcnt - 2'd1;
                    end
                end
                S_HOLD: begin
                    if (!hold_req) begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Access context captured at acceptance; beat counter and first flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q     <= '0;
            write_q    <= 1'b0;
            first_q    <= 1'b0;
            lanes_q    <= 4'h0;
            len_q      <= 4'd0;
            beats_left <= 4'd0;
            wdata_q    <= 32'd0;
        end else if (accept) begin
            attr_q     <= attr_in;
            write_q    <= req_write;
            first_q    <= 1'b1;
            lanes_q    <= req_lanes;
            len_q      <= len_eff;
            beats_left <= len_eff;
            wdata_q    <= req_wdata;
        end else if (beat_done) begin
            first_q <= 1'b0;
            if (!finish) begin
                beats_left <= beats_left - 4'd1;
            end
        end
    end

    // Client-side results: read data per beat and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'd0;
            done     <= 1'b0;
            done_err <= 1'b0;
        end else begin
            rd_valid <= beat_done && !write_q;
            done     <= finish;
            if (beat_done && !write_q) begin
                rd_data <= bus_in;
            end
            if (finish) begin
                done_err <= !bus_err_n;
            end else if (done) begin
                done_err <= 1'b0;
            end
        end
    end

    // Pin values: address word, write data, strobes and handshake outputs.
    always_comb begin
        ale       = (state == S_ADDR);
        wr        = (state == S_ADDR) && write_q;
        blast     = active && (beats_left == 4'd0);
        bus_width = active ? attr_q.width : 2'b00;
        part_addr = active ? cur_addr[3:2] : 2'b00;
        hold_ack  = (state == S_HOLD);
        ctl_oe    = (state != S_HOLD);
        bus_req   = (state == S_HOLD) ? req_valid : (active || state == S_RECOV);
        bus_oe    = (state == S_ADDR) || ((state == S_DATA) && write_q);
        if (state == S_ADDR) begin
            bus_out = {cur_addr[7:4], len_q, cur_addr[15:8],
                       cur_addr[23:16], cur_addr[31:24]};
        end else if ((state == S_DATA) && write_q) begin
            bus_out = wdata_q;
        end else begin
            bus_out = 32'd0;
        end
    end
endmodule

// File: rtl/mbus_ctrl_chk.sv
// Property checker for the bus sequencer, attached by bind.
// Assumes the top-level port names of mbus_ctrl.
module mbus_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ale,
    input logic       wr,
    input logic       req_ready,
    input logic       hold_req,
    input logic       hold_ack,
    input logic       ctl_oe,
    input logic       bus_oe,
    input logic [1:0] bus_width,
    input logic       done,
    input logic       rdy
);
    timeunit 1ns;
    timeprecision 1ps;

    // R2: address phase lasts one cycle.
    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R2: write indication only inside the address phase.
    assert_wr_in_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> ale);

    // R6: the reserved width code never reaches the pins in an access.
    assert_width_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (bus_width != 2'b11));

    // R12: while the bus is handed over, every driver is released.
    assert_hold_float_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!ctl_oe && !bus_oe && !ale));

    // R12: acknowledge drops one cycle after the request is seen low.
    assert_hold_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && !hold_req) |=> !hold_ack);

    // R12: no new request is taken while a hold is asked for.
    assert_no_accept_in_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |-> !req_ready);

    // R11: completion follows a cycle in which ready was sampled.
    assert_done_after_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rdy));
endmodule

bind mbus_ctrl mbus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale       (ale),
    .wr        (wr),
    .req_ready (req_ready),
    .hold_req  (hold_req),
    .hold_ack  (hold_ack),
    .ctl_oe    (ctl_oe),
    .bus_oe    (bus_oe),
    .bus_width (bus_width),
    .done      (done),
    .rdy       (rdy)
);

// File: tb/mbus_ctrl_test.sv
// Scoreboard bench for mbus_ctrl: a driver task predicts each access and
// queues the expected observations; a falling-edge monitor compares them.
module mbus_ctrl_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] region_cfg;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = 32'd0;
    logic [3:0]  req_len = 4'd0;
    logic [3:0]  req_lanes = 4'hF;
    logic [31:0] req_wdata = 32'd0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        done;
    logic        done_err;
    logic [31:0] bus_out;
    logic [31:0] bus_in = 32'd0;
    logic        bus_oe;
    logic        ctl_oe;
    logic        ale;
    logic        wr;
    logic [3:0]  be_n;
    logic [1:0]  part_addr;
    logic        blast;
    logic [1:0]  bus_width;
    logic        rdy = 1'b0;
    logic        bus_err_n = 1'b1;
    logic        hold_req = 1'b0;
    logic        hold_ack;
    logic        bus_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit wait_flag = 1'b0;
    bit wait_last = 1'b0;
    bit cur_write = 1'b0;

    typedef struct {
        int          kind;   // 0 address, 1 beat, 2 done
        logic [31:0] word;
        logic [3:0]  be;
        logic [1:0]  pa;
        logic        b1;
        logic        b2;
        logic [1:0]  w;
    } exp_t;

    exp_t        exp_q [$];
    logic [31:0] rd_q [$];
    exp_t        it;
    logic [31:0] rd_exp;

    always #2 clk = ~clk;

    mbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .region_cfg(region_cfg),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_lanes(req_lanes),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .done_err(done_err), .bus_out(bus_out), .bus_in(bus_in),
        .bus_oe(bus_oe), .ctl_oe(ctl_oe), .ale(ale), .wr(wr), .be_n(be_n),
        .part_addr(part_addr), .blast(blast), .bus_width(bus_width),
        .rdy(rdy), .bus_err_n(bus_err_n), .hold_req(hold_req),
        .hold_ack(hold_ack), .bus_req(bus_req)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] m_be(input logic [31:0] a, input logic [1:0] w,
                                        input logic [3:0] m);
        if (w == 2'b00)      m_be = {2'b11, a[1], a[0]};
        else if (w == 2'b01) m_be = {1'b1, 1'b0, a[1], 1'b0};
        else                 m_be = ~m;
    endfunction

    function automatic int m_step(input logic [1:0] w);
        m_step = (w == 2'b00) ? 1 : ((w == 2'b01) ? 2 : 4);
    endfunction

    // Monitor: pops and compares expected items as results appear.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (ale || (rdy && !ale) || done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected bus event", 32'd1, 32'd0);
                end else begin
                    it = exp_q.pop_front();
                    if (ale) begin
                        chk(it.kind == 0, "R2 item order (address)", it.kind, 0);
                        chk(bus_out == it.word, "R3 address word", bus_out, it.word);
                        chk(bus_out[27:24] == it.word[27:24], "R4 length code",
                            bus_out[27:24], it.word[27:24]);
                        chk(be_n == it.be, "R7 address cycle enables", be_n, it.be);
                        chk(wr == it.b1, "R2 write indication", wr, it.b1);
                        chk(bus_width == it.w, "R6 width code", bus_width, it.w);
                        chk(blast == it.b2, "R5 blast in address cycle", blast, it.b2);
                        chk(part_addr == it.pa, "R8 address cycle word bits", part_addr, it.pa);
                        chk(bus_oe && bus_req && !hold_ack, "R13 drive in address cycle",
                            {bus_oe, bus_req, hold_ack}, 3'b110);
                    end else if (rdy) begin
                        chk(it.kind == 1, "R5 item order (beat)", it.kind, 1);
                        chk(be_n == it.be, "R7 beat enables", be_n, it.be);
                        chk(part_addr == it.pa, "R8 beat word bits", part_addr, it.pa);
                        chk(blast == it.b1, "R5 blast on beat", blast, it.b1);
                        chk(wr == 1'b0, "R2 wr low in data", wr, 0);
                        chk(bus_req && !hold_ack, "R12 no hold during access",
                            {bus_req, hold_ack}, 2'b10);
                        if (cur_write) begin
                            chk(bus_oe && bus_out == it.word, "R9 write data", bus_out, it.word);
                        end
                    end else begin
                        chk(it.kind == 2, "R11 item order (done)", it.kind, 2);
                        chk(done_err == it.b1, "R10 error status", done_err, it.b1);
                    end
                end
            end
            if (wait_flag) begin
                chk(blast == wait_last, "R5 blast during wait", blast, wait_last);
            end
            if (rd_valid) begin
                if (rd_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected read data", rd_data, 32'd0);
                end else begin
                    rd_exp = rd_q.pop_front();
                    chk(rd_data == rd_exp, "R9 read data", rd_data, rd_exp);
                end
            end
        end
    end

    // Driver: predicts, queues and drives one access.
    task automatic run_acc(input logic [31:0] a, input logic wr_i, input logic [3:0] len,
                           input logic [3:0] lanes, input logic [31:0] wd, input int waits,
                           input int err_beat, input bit err_in_wait, input bit hold_mid);
        logic [5:0]  f;
        logic [1:0]  w;
        int          rec;
        logic        mb;
        logic        twf;
        logic [3:0]  lcode;
        int          nb;
        int          last;
        logic [31:0] start;
        logic [31:0] cur;
        logic [31:0] sum;
        logic [31:0] dat [16];
        exp_t        e;
        int          cnt;
        bit          err_hit;
        f     = region_cfg[a[31:29]*6 +: 6];
        w     = (f[1:0] == 2'b11) ? 2'b10 : f[1:0];
        rec   = int'(f[3:2]);
        mb    = f[4];
        twf   = f[5];
        lcode = mb ? len : {2'b00, len[1:0]};
        nb    = int'(lcode) + 1;
        start = a & ~(32'(m_step(w)) - 32'd1);
        if (nb > 1 && !mb && !twf) start[3:0] = 4'd0;
        err_hit = (err_beat >= 0) && (err_beat < nb);
        last  = err_hit ? err_beat : nb - 1;
        e = '{kind: 0, word: {start[7:4], lcode, start[15:8], start[23:16], start[31:24]},
              be: m_be(start, w, lanes), pa: start[3:2], b1: wr_i, b2: (nb == 1), w: w};
        exp_q.push_back(e);
        cur = start;
        for (int k = 0; k <= last; k++) begin
            dat[k] = 32'hA500_0000 ^ (a + 32'(k * 7));
            e = '{kind: 1, word: wd, be: m_be(cur, w, (k == 0) ? lanes : 4'hF),
                  pa: cur[3:2], b1: (k == nb - 1), b2: 1'b0, w: w};
            exp_q.push_back(e);
            if (!wr_i) rd_q.push_back(dat[k]);
            sum = cur + 32'(m_step(w));
            cur = mb ? sum : {cur[31:4], sum[3:0]};
        end
        e = '{kind: 2, word: 32'd0, be: 4'h0, pa: 2'd0, b1: err_hit, b2: 1'b0, w: 2'd0};
        exp_q.push_back(e);
        @(posedge clk); #1;
        cur_write = wr_i;
        req_valid = 1'b1; req_write = wr_i; req_addr = a; req_len = len;
        req_lanes = lanes; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (hold_mid) hold_req = 1'b1;
        @(posedge clk); #1;
        for (int k = 0; k <= last; k++) begin
            for (int j = 0; j < waits; j++) begin
                rdy = 1'b0;
                bus_err_n = err_in_wait ? 1'b0 : 1'b1;
                wait_last = (k == nb - 1);
                wait_flag = 1'b1;
                @(posedge clk); #1;
            end
            wait_flag = 1'b0;
            rdy = 1'b1;
            bus_err_n = (k == err_beat) ? 1'b0 : 1'b1;
            bus_in = dat[k];
            @(posedge clk); #1;
        end
        rdy = 1'b0;
        bus_err_n = 1'b1;
        if (!hold_mid) begin
            cnt = 0;
            forever begin
                @(negedge clk);
                if (req_ready || cnt > 8) break;
                chk(bus_req == 1'b1, "R13 bus_req in recovery", bus_req, 1);
                cnt++;
            end
            chk(cnt == rec, "R11 recovery cycles", cnt, rec);
        end else begin
            @(negedge clk);
            chk(!hold_ack && !req_ready, "R12 hold waits for access end",
                {hold_ack, req_ready}, 2'b00);
            @(negedge clk);
            chk(hold_ack && !ctl_oe && !bus_oe, "R12 hold granted after access",
                {hold_ack, ctl_oe, bus_oe}, 3'b100);
            @(posedge clk); #1;
            hold_req = 1'b0;
            @(negedge clk);
            chk(hold_ack == 1'b1, "R12 ack still high in drop cycle", hold_ack, 1);
            @(negedge clk);
            chk(hold_ack == 1'b0, "R12 ack drops next cycle", hold_ack, 0);
        end
    endtask

    initial begin
        region_cfg = '0;
        region_cfg[0*6 +: 6] = 6'b100010; // 32-bit, four-beat, recov 0, target first
        region_cfg[1*6 +: 6] = 6'b000101; // 16-bit, four-beat, recov 1, sequential
        region_cfg[2*6 +: 6] = 6'b111000; // 8-bit, long bursts, recov 2
        region_cfg[3*6 +: 6] = 6'b011110; // 32-bit, long bursts, recov 3
        region_cfg[4*6 +: 6] = 6'b000011; // reserved width code, recov 0
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!ale && be_n == 4'hF && !blast && !bus_oe, "R7 reset outputs idle",
            {ale, be_n, blast, bus_oe}, {1'b0, 4'hF, 2'b00});
        chk(req_ready && !hold_ack && ctl_oe && !bus_req, "R12 reset handshake",
            {req_ready, hold_ack, ctl_oe, bus_req}, 4'b1010);

        run_acc(32'h0000_0104, 1'b0, 4'd0,  4'b0011, 32'd0, 2, -1, 1'b0, 1'b0); // R5 R7 single
        run_acc(32'h0000_0208, 1'b0, 4'd3,  4'hF, 32'd0, 1, -1, 1'b0, 1'b0);    // R8 wrap, R1
        run_acc(32'h2000_0006, 1'b1, 4'd3,  4'hF, 32'h1234_5678, 0, -1, 1'b0, 1'b0); // R8 line base
        run_acc(32'h4000_0003, 1'b0, 4'd5,  4'hF, 32'd0, 1, -1, 1'b0, 1'b0);    // R4 long, 8-bit
        run_acc(32'h6000_0010, 1'b1, 4'd15, 4'b1110, 32'hCAFE_F00D, 0, -1, 1'b0, 1'b0); // R4 16 beats
        run_acc(32'h0000_0000, 1'b0, 4'd6,  4'hF, 32'd0, 0, -1, 1'b0, 1'b0);    // R4 truncation
        run_acc(32'h2000_0010, 1'b0, 4'd3,  4'hF, 32'd0, 1, 1, 1'b0, 1'b0);     // R10 error
        run_acc(32'h8000_0020, 1'b0, 4'd0,  4'hF, 32'd0, 3, -1, 1'b1, 1'b0);    // R1 R6 R10 ignore

        // R12/R13: hold granted from idle, bus_req follows req_valid.
        @(posedge clk); #1 hold_req = 1'b1;
        @(negedge clk);
        chk(!req_ready && !hold_ack, "R12 req_ready low under hold request",
            {req_ready, hold_ack}, 2'b00);
        @(negedge clk);
        chk(hold_ack && !ctl_oe && !bus_oe, "R12 hold granted from idle",
            {hold_ack, ctl_oe, bus_oe}, 3'b100);
        chk(!bus_req, "R13 bus_req idle while held", bus_req, 0);
        @(posedge clk); #1 req_valid = 1'b1; req_addr = 32'h0000_0300;
        @(negedge clk);
        chk(bus_req && !ale, "R13 bus_req shows pending work", {bus_req, ale}, 2'b10);
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        chk(!bus_req, "R13 bus_req follows req_valid", bus_req, 0);
        @(posedge clk); #1 hold_req = 1'b0;
        @(negedge clk);
        chk(hold_ack, "R12 ack held in drop cycle", hold_ack, 1);
        @(negedge clk);
        chk(!hold_ack && ctl_oe, "R12 ack released", {hold_ack, ctl_oe}, 2'b01);

        run_acc(32'h0000_0040, 1'b1, 4'd0, 4'hF, 32'h0F0F_0F0F, 3, -1, 1'b0, 1'b1); // R12 mid

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all bus events seen", exp_q.size(), 0);
        chk(rd_q.size() == 0, "R9 all read data seen", rd_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule